// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens an 8-bit raster image along the slow-scan axis, one line against the lines next to it. Each accepted sample brings three pixels from the same column: the line arriving now (below), the line one step older (centre) and the line two steps older (above). The centre pixel is corrected by adding a scaled second difference of its vertical neighbours: out = centre + K·(2·centre − (above + below)). Surrounding line buffers supply the three aligned pixels; this block holds no line storage and does no horizontal filtering.

The coefficient K is an unsigned fixed-point value that travels with each sample, so it may change from one sample to the next. The datapath is a three-register pipeline: the first register holds the signed second difference, the second holds the scaled correction, and the third holds the sum, which is saturated into the pixel range. Each stage loads only when its incoming valid bit is set, so idle cycles leave the data registers unchanged while the valid bits march on.

The pipeline has no control states: the valid bits in the three stages are its whole sequencing, with two behaviours per stage, load (valid in high) and hold (valid in low).

Top module: `vertical_sharpen`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly three rising clock edges; each sample accepted on edge c produces its result on `pix_out` after edge c+3.
- R2: While `rst_n` is low and after its release, before any accepted sample has emerged, `out_valid` is 0 and `pix_out` is 0.
- R3: For in-range results, `pix_out` = centre + floor(K·(2·centre − above − below) / 4), where K is the unsigned value on `coef_k`.
- R4: With `coef_k` = 0 the output equals the centre pixel whatever the neighbours are.
- R5: A negative scaled correction is rounded toward negative infinity (K = 1, second difference −1 lowers the centre by 1), never toward zero.
- R6: A result above 255 is output as 255.
- R7: A result below 0 is output as 0.
- R8: A cycle with `in_valid` low is ignored: the pixel and coefficient inputs on that cycle have no effect, and `pix_out` keeps its last value during every cycle in which `out_valid` is low.
- R9: The coefficient is captured together with its pixels; back-to-back samples with different coefficients are each scaled by their own K.
- R10: `coef_k` is 4 bits: bits [3:2] are the integer part and bits [1:0] the fraction, so the code 4 means 1.0 and the code 15 means 3.75.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the three pixels and coefficient as a sample |
| pix_prev2 | input | 8 | Pixel from the line two steps older (above) |
| pix_prev1 | input | 8 | Pixel from the line one step older (centre) |
| pix_curr | input | 8 | Pixel from the incoming line (below) |
| coef_k | input | 4 | Sharpening coefficient, two fraction bits |
| out_valid | output | 1 | Marks `pix_out` as a new result |
| pix_out | output | 8 | Sharpened, saturated centre pixel |

## Verification
The bench aims at the rounding of a negative correction (a design that truncates toward zero would return the centre pixel unchanged where one less is expected), and at both saturation edges, where a design without clamping would wrap 256 into 0 or −1 into 255. It interleaves idle cycles carrying junk pixels and coefficients, which catches a pipeline that loads on every edge or moves `pix_out` between results, and it changes K every sample so that a coefficient taken one stage late shows up as a wrong scale. Every result is stamped with the cycle it is due in, so a pipeline one register short or long fails on timing even when the value matches.

// File: rtl/lap_pkg.sv
package lap_pkg;
    localparam int unsigned PIX_W_DEF  = 8;
    localparam int unsigned K_W_DEF    = 4;
    localparam int unsigned K_FRAC_DEF = 2;
    localparam int unsigned STAGES     = 3;

    typedef enum logic {
        STG_HOLD = 1'b0,
        STG_LOAD = 1'b1
    } stage_act_e;
endpackage

// File: rtl/lap_diff_stage.sv
module lap_diff_stage
    import lap_pkg::*;
#(
    parameter int unsigned PIX_W = PIX_W_DEF,
    parameter int unsigned K_W   = K_W_DEF,
    localparam int unsigned DW   = PIX_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_in,
    input  logic [PIX_W-1:0]     above,
    input  logic [PIX_W-1:0]     centre,
    input  logic [PIX_W-1:0]     below,
    input  logic [K_W-1:0]       k_in,
    output logic                 v_q,
    output logic [PIX_W-1:0]     centre_q,
    output logic [K_W-1:0]       k_q,
    output logic signed [DW-1:0] diff_q
);
    stage_act_e      act;
    logic [DW-1:0]   pair_sum;
    logic [DW-1:0]   twice_c;
    logic [DW-1:0]   diff_u;

    always_comb begin
        act      = v_in ? STG_LOAD : STG_HOLD;
        pair_sum = {2'b00, above} + {2'b00, below};
        twice_c  = {1'b0, centre, 1'b0};
        diff_u   = twice_c - pair_sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q      <= 1'b0;
            centre_q <= '0;
            k_q      <= '0;
            diff_q   <= '0;
        end else begin
            v_q <= v_in;
            unique case (act)
                STG_LOAD: begin
                    centre_q <= centre;
                    k_q      <= k_in;
                    diff_q   <= $signed(diff_u);
                end
                STG_HOLD: ;
            endcase
        end
    end

    logic live_q;
    always_ff @(posedge clk) live_q <= rst_n;

    p_valid_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (v_q == $past(v_in)));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !v_in |=> ($stable(diff_q) && $stable(k_q) && $stable(centre_q)));
    p_flat_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        v_in && (above == centre) && (below == centre) |=> (diff_q == 0));
endmodule

// File: rtl/lap_scale_stage.sv
module lap_scale_stage
    import lap_pkg::*;
#(
    parameter int unsigned PIX_W = PIX_W_DEF,
    parameter int unsigned K_W   = K_W_DEF,
    localparam int unsigned DW   = PIX_W + 2,
    localparam int unsigned PW   = DW + K_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_in,
    input  logic [PIX_W-1:0]     centre_in,
    input  logic [K_W-1:0]       k_in,
    input  logic signed [DW-1:0] diff_in,
    output logic                 v_q,
    output logic [PIX_W-1:0]     centre_q,
    output logic signed [PW-1:0] prod_q
);
    stage_act_e         act;
    logic signed [PW-1:0] diff_ext;
    logic signed [PW-1:0] k_ext;
    logic signed [PW-1:0] prod_c;

    always_comb begin
        act      = v_in ? STG_LOAD : STG_HOLD;
        diff_ext = {{K_W{diff_in[DW-1]}}, diff_in};
        k_ext    = {{DW{1'b0}}, k_in};
        prod_c   = diff_ext * k_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q      <= 1'b0;
            centre_q <= '0;
            prod_q   <= '0;
        end else begin
            v_q <= v_in;
            unique case (act)
                STG_LOAD: begin
                    centre_q <= centre_in;
                    prod_q   <= prod_c;
                end
                STG_HOLD: ;
            endcase
        end
    end

    logic live_q;
    always_ff @(posedge clk) live_q <= rst_n;

    p_valid_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (v_q == $past(v_in)));
    p_zero_coef_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v_in && (k_in == '0) |=> (prod_q == 0));
    p_sign_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        v_in && (k_in != '0) && (diff_in < 0) |=> (prod_q < 0));
endmodule

// File: rtl/lap_clamp_stage.sv
module lap_clamp_stage
    import lap_pkg::*;
#(
    parameter int unsigned PIX_W  = PIX_W_DEF,
    parameter int unsigned K_W    = K_W_DEF,
    parameter int unsigned K_FRAC = K_FRAC_DEF,
    localparam int unsigned PW    = PIX_W + 2 + K_W,
    localparam int unsigned SW    = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_in,
    input  logic [PIX_W-1:0]     centre_in,
    input  logic signed [PW-1:0] prod_in,
    output logic                 v_q,
    output logic [PIX_W-1:0]     pix_q
);
    localparam logic signed [SW-1:0] PIX_MAX = SW'((1 << PIX_W) - 1);

    stage_act_e           act;
    logic signed [PW-1:0] corr;
    logic signed [SW-1:0] total;
    logic [PIX_W-1:0]     sat;

    always_comb begin
        act   = v_in ? STG_LOAD : STG_HOLD;
        corr  = prod_in >>> K_FRAC;
        total = $signed({{(SW-PIX_W){1'b0}}, centre_in}) + $signed({corr[PW-1], corr});
        if (total < 0)
            sat = '0;
        else if (total > PIX_MAX)
            sat = '1;
        else
            sat = total[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            pix_q <= '0;
        end else begin
            v_q <= v_in;
            unique case (act)
                STG_LOAD: pix_q <= sat;
                STG_HOLD: ;
            endcase
        end
    end

    logic live_q;
    always_ff @(posedge clk) live_q <= rst_n;

    p_valid_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (v_q == $past(v_in)));
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !v_in |=> $stable(pix_q));
    p_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        v_in && (prod_in > 0) |=> (pix_q >= $past(centre_in)));
    p_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        v_in && (prod_in < 0) |=> (pix_q <= $past(centre_in)));
endmodule

// File: rtl/vertical_sharpen.sv
module vertical_sharpen
    import lap_pkg::*;
#(
    parameter int unsigned PIX_W  = PIX_W_DEF,
    parameter int unsigned K_W    = K_W_DEF,
    parameter int unsigned K_FRAC = K_FRAC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] pix_prev2,
    input  logic [PIX_W-1:0] pix_prev1,
    input  logic [PIX_W-1:0] pix_curr,
    input  logic [K_W-1:0]   coef_k,
    output logic             out_valid,
    output logic [PIX_W-1:0] pix_out
);
    localparam int unsigned DW = PIX_W + 2;
    localparam int unsigned PW = DW + K_W;

    logic                 s1_v, s2_v;
    logic [PIX_W-1:0]     s1_c, s2_c;
    logic [K_W-1:0]       s1_k;
    logic signed [DW-1:0] s1_diff;
    logic signed [PW-1:0] s2_prod;

    lap_diff_stage #(.PIX_W(PIX_W), .K_W(K_W)) u_diff (
        .clk(clk), .rst_n(rst_n), .v_in(in_valid),
        .above(pix_prev2), .centre(pix_prev1), .below(pix_curr), .k_in(coef_k),
        .v_q(s1_v), .centre_q(s1_c), .k_q(s1_k), .diff_q(s1_diff)
    );

    lap_scale_stage #(.PIX_W(PIX_W), .K_W(K_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .v_in(s1_v),
        .centre_in(s1_c), .k_in(s1_k), .diff_in(s1_diff),
        .v_q(s2_v), .centre_q(s2_c), .prod_q(s2_prod)
    );

    lap_clamp_stage #(.PIX_W(PIX_W), .K_W(K_W), .K_FRAC(K_FRAC)) u_clamp (
        .clk(clk), .rst_n(rst_n), .v_in(s2_v),
        .centre_in(s2_c), .prod_in(s2_prod),
        .v_q(out_valid), .pix_q(pix_out)
    );

    p_reset_quiet_r2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (pix_out == '0)));
endmodule

// File: tb/test_vertical_sharpen.sv
module test_vertical_sharpen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] pix_prev2 = '0, pix_prev1 = '0, pix_curr = '0;
    logic [3:0] coef_k = '0;
    logic       out_valid;
    logic [7:0] pix_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    bit armed = 0;
    int last_pix = 0;

    typedef struct { int val; int due; string req; } exp_t;
    exp_t sb[$];

    vertical_sharpen i_vertical_sharpen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pix_prev2(pix_prev2), .pix_prev1(pix_prev1), .pix_curr(pix_curr),
        .coef_k(coef_k), .out_valid(out_valid), .pix_out(pix_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R3, R5, R6, R7, R10: reference model, K in quarters, floor division
    function automatic int model(int a, int n, int b, int k);
        int d, p, q, r;
        d = 2 * n - a - b;
        p = k * d;
        if (p >= 0) q = p / 4;
        else        q = -((-p + 3) / 4);
        r = n + q;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic send(int a, int n, int b, int k, string req);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        pix_prev2 = 8'(a);
        pix_prev1 = 8'(n);
        pix_curr  = 8'(b);
        coef_k    = 4'(k);
        e.val = model(a, n, b, k);
        e.due = cyc + 3;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            pix_prev2 = 8'($urandom);
            pix_prev1 = 8'($urandom);
            pix_curr  = 8'($urandom);
            coef_k    = 4'($urandom);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (armed && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R1 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R1 result cycle", cyc, e.due);
                    chk(int'(pix_out) == e.val, e.req, int'(pix_out), e.val);
                end
                last_pix = int'(pix_out);
            end else begin
                chk(int'(pix_out) == last_pix, "R8 output hold while idle", int'(pix_out), last_pix);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R2 out_valid in reset", int'(out_valid), 0);
        chk(pix_out == 8'd0, "R2 pix_out in reset", int'(pix_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 out_valid after release", int'(out_valid), 0);
        chk(pix_out == 8'd0, "R2 pix_out after release", int'(pix_out), 0);
        armed = 1;

        send(10, 200, 90, 0, "R4 zero coefficient");
        send(255, 3, 0, 0, "R4 zero coefficient extreme");
        send(100, 120, 100, 4, "R3 K=1.0 sharpen");
        send(51, 50, 50, 1, "R5 floor of -1/4");
        send(0, 2, 1, 2, "R3 K=0.5 positive floor");
        send(0, 250, 0, 15, "R6 saturate high");
        send(255, 5, 255, 15, "R7 saturate low");
        send(255, 0, 255, 15, "R7 extreme negative");
        send(0, 255, 0, 15, "R6 extreme positive");
        send(60, 80, 70, 10, "R10 K=2.5");
        idle(5);
        // R9: same pixels, coefficient changes every sample
        for (int k = 0; k < 16; k++) send(40, 70, 90, k, "R9 per-sample coefficient");
        idle(4);
        // R8: random traffic with junk on idle cycles
        for (int i = 0; i < 300; i++) begin
            send(int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), int'($urandom_range(15)), "R3 random sample");
            if ($urandom_range(3) == 0) idle(int'($urandom_range(4)) + 1);
        end
        idle(8);
        chk(sb.size() == 0, "R1 all results delivered", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule